// File: doc/BRIEF.md
# Masked vector load unit

This unit carries out one predicated vector load at a time. A request names a base address, an element width (32 or 64 bits), a vector length of one, two or four 128-bit lanes, a per-element predicate mask, a write-back mode (merge or zero) and an optional whole-vector alignment demand. The unit walks the elements in ascending order. It fetches only the elements whose predicate bit is set, one element per accepted memory beat. It then combines the fetched data with the previous destination contents and writes the result in a single register write.

A scalar form moves only the lowest element. A request that breaks the alignment rule ends with an alignment fault. A faulting memory beat ends the request with a memory fault. In both cases the register is not written. Completion is signalled by a one-cycle `done` pulse, which carries a fault code.

Both the request port and the memory read port use valid/ready. The request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle. On the memory side, `mem_rd_valid` and `mem_rd_addr` stay fixed until the cycle in which `mem_rd_ready` is high. In that same cycle `mem_rd_data` and `mem_rd_fault` carry the response.

Top module: `masked_vec_load`

## Requirements
- R1: `req_lanes` gives the lane count: 0 means 1 lane, 1 means 2 lanes, and 2 or 3 mean 4 lanes. The element count is 4 per lane for 32-bit elements (`req_elem64`=0) and 2 per lane for 64-bit elements. Mask bit n governs element n, which is read at base + 4n (32-bit) or base + 8n (64-bit). Element n occupies bits [32n+31:32n] or [64n+63:64n] of the vector. A 32-bit element takes `mem_rd_data[31:0]`. Mask bits at or above the element count are ignored.
- R2: An element whose mask bit is clear is never requested from memory and is zero in the loaded value. An all-zero mask makes no memory access at all.
- R3: In zero mode (`req_zero`=1), each element inside the active length is the loaded data if its mask bit is set and zero otherwise.
- R4: In merge mode (`req_zero`=0), each element inside the active length whose mask bit is clear keeps the value sampled from `dst_old` when the request was taken.
- R5: All bits of `reg_wr_data` above the active vector length (128 × lanes) are zero in both modes.
- R6: When `req_aligned`=1 and the request is not scalar, a base address that is not a multiple of 16 × lanes bytes ends the request with `fault_code`=1. In that case there is no memory access and no register write. When `req_aligned`=0, any address is accepted.
- R7: A beat that returns `mem_rd_fault`=1 for a selected element ends the request with `fault_code`=2, and there is no register write. A fault can only come from an element that is actually requested.
- R8: With `req_scalar`=1, only element 0 and mask bit 0 count, and `req_lanes` and `req_aligned` are ignored. If mask bit 0 is set, element 0 is loaded. If it is clear, element 0 is the old value (merge mode) or zero (zero mode). All higher bits are zero.
- R9: A memory request held while `mem_rd_ready`=0 keeps `mem_rd_valid` high and `mem_rd_addr` unchanged. `req_ready` is low from acceptance until completion.
- R10: A successful request raises `reg_wr_en` for exactly one cycle. `done` follows one cycle later, for one cycle, with `fault_code`=0.
- R11: After reset, `req_ready`=1 and `mem_rd_valid`, `reg_wr_en` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_addr | input | ADDR_W | Base address |
| req_elem64 | input | 1 | 1 selects 64-bit elements, 0 selects 32-bit elements |
| req_lanes | input | LCW | Lane count code (see R1) |
| req_mask | input | 4×LANES_MAX | Per-element predicate |
| req_zero | input | 1 | 1 for zero mode, 0 for merge mode |
| req_aligned | input | 1 | Demand whole-vector alignment |
| req_scalar | input | 1 | Move only element 0 |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory accepts the request and returns its response |
| mem_rd_addr | output | ADDR_W | Element address |
| mem_rd_data | input | 64 | Read data, valid in the handshake cycle |
| mem_rd_fault | input | 1 | Read fault, valid in the handshake cycle |
| dst_old | input | 128×LANES_MAX | Previous destination contents, sampled when the request is taken |
| reg_wr_en | output | 1 | Destination write strobe |
| reg_wr_data | output | 128×LANES_MAX | Destination write value |
| done | output | 1 | Completion pulse |
| fault_code | output | 2 | 0 ok, 1 alignment, 2 memory; valid with `done` |

## Verification
The bench builds the unit with LANES_MAX=4 and ADDR_W=32, so the vector is 512 bits wide and the mask is 16 bits. These values bring all three lane counts into reach, along with both element widths and the clamped lane code. The lane counts give three alignment sizes (16, 32 and 64 bytes) and upper-bit clearing of 384 or 256 bits. The memory model stalls `mem_rd_ready` in a repeating pattern to exercise back-pressure. It can also fault on one chosen address, which lets the bench place that address on either a selected element or a masked-off element.

// File: rtl/mvl_pkg.sv
package mvl_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CHECK,
    SQ_FETCH,
    SQ_WRITE,
    SQ_DONE
  } sq_state_e;

  localparam logic [1:0] FC_NONE  = 2'd0;
  localparam logic [1:0] FC_ALIGN = 2'd1;
  localparam logic [1:0] FC_MEM   = 2'd2;
endpackage

// File: rtl/mvl_shape.sv
module mvl_shape #(
  parameter int LANES_MAX = 4,
  parameter int ADDR_W    = 32,
  localparam int LOG_MAX  = $clog2(LANES_MAX),
  localparam int LCW      = (LOG_MAX < 1) ? 1 : $clog2(LOG_MAX + 1),
  localparam int MASK_W   = 4 * LANES_MAX,
  localparam int CNT_W    = $clog2(MASK_W) + 1,
  localparam int AW_W     = $clog2(4 * LANES_MAX) + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              elem64,
  input  logic [LCW-1:0]    lanes_code,
  input  logic              scalar,
  input  logic              aligned,
  output logic [CNT_W-1:0]  elem_cnt,
  output logic [AW_W-1:0]   act_words,
  output logic              misaligned
);
  int log_eff;
  int lanes;
  int vec_bytes;

  always_comb begin
    log_eff   = (int'(lanes_code) > LOG_MAX) ? LOG_MAX : int'(lanes_code);
    lanes     = 1 << log_eff;
    vec_bytes = 16 * lanes;
    misaligned = aligned && !scalar &&
                 ((addr & ADDR_W'(vec_bytes - 1)) != '0);
    if (scalar) begin
      elem_cnt  = CNT_W'(1);
      act_words = elem64 ? AW_W'(2) : AW_W'(1);
    end else begin
      elem_cnt  = elem64 ? CNT_W'(2 * lanes) : CNT_W'(4 * lanes);
      act_words = AW_W'(4 * lanes);
    end
  end
endmodule

// File: rtl/mvl_seq.sv
module mvl_seq
  import mvl_pkg::*;
#(
  parameter int LANES_MAX = 4,
  parameter int ADDR_W    = 32,
  localparam int MASK_W   = 4 * LANES_MAX,
  localparam int WORDS    = 4 * LANES_MAX,
  localparam int VW       = 32 * WORDS,
  localparam int IDX_W    = $clog2(MASK_W),
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              misaligned,
  input  logic [CNT_W-1:0]  elem_cnt,
  input  logic [MASK_W-1:0] mask,
  input  logic              elem64,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [63:0]       mem_rd_data,
  input  logic              mem_rd_fault,
  output logic [VW-1:0]     loaded,
  output logic              idle,
  output logic              wr_en,
  output logic              done,
  output logic [1:0]        fault_code
);
  sq_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       fault_q;
  logic [VW-1:0]    lbuf_q;
  logic             cur_sel;
  logic             last_elem;
  logic             hs;
  logic             cap_we;

  assign cur_sel      = mask[idx_q];
  assign last_elem    = (CNT_W'(idx_q) == elem_cnt - CNT_W'(1));
  assign mem_rd_valid = (state_q == SQ_FETCH) && cur_sel;
  assign hs           = mem_rd_valid && mem_rd_ready;
  assign cap_we       = hs && !mem_rd_fault;
  assign mem_rd_addr  = base_addr + (ADDR_W'(idx_q) << (elem64 ? 3 : 2));
  assign idle         = (state_q == SQ_IDLE);
  assign wr_en        = (state_q == SQ_WRITE);
  assign done         = (state_q == SQ_DONE);
  assign fault_code   = fault_q;
  assign loaded       = lbuf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      fault_q <= FC_NONE;
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          state_q <= SQ_CHECK;
          idx_q   <= '0;
          fault_q <= FC_NONE;
        end
        SQ_CHECK: begin
          if (misaligned) begin
            fault_q <= FC_ALIGN;
            state_q <= SQ_DONE;
          end else begin
            state_q <= SQ_FETCH;
          end
        end
        SQ_FETCH: begin
          if (hs && mem_rd_fault) begin
            fault_q <= FC_MEM;
            state_q <= SQ_DONE;
          end else if (!cur_sel || hs) begin
            if (last_elem) state_q <= SQ_WRITE;
            else           idx_q   <= idx_q + IDX_W'(1);
          end
        end
        SQ_WRITE: state_q <= SQ_DONE;
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end

  // Element buffer: cleared per request, so unselected elements stay zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbuf_q <= '0;
    end else if (start && idle) begin
      lbuf_q <= '0;
    end else if (cap_we) begin
      for (int w = 0; w < WORDS; w++) begin
        if (elem64 ? ((w / 2) == int'(idx_q)) : (w == int'(idx_q)))
          lbuf_q[w*32 +: 32] <= (elem64 && (w % 2 == 1)) ? mem_rd_data[63:32]
                                                         : mem_rd_data[31:0];
      end
    end
  end

  p_hold_under_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_done_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (done && fault_code == FC_NONE));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/mvl_merge.sv
module mvl_merge #(
  parameter int LANES_MAX = 4,
  localparam int WORDS    = 4 * LANES_MAX,
  localparam int VW       = 32 * WORDS,
  localparam int MASK_W   = 4 * LANES_MAX,
  localparam int AW_W     = $clog2(WORDS) + 1
) (
  input  logic [VW-1:0]     loaded,
  input  logic [VW-1:0]     old_val,
  input  logic [MASK_W-1:0] mask,
  input  logic              elem64,
  input  logic              zero_mode,
  input  logic [AW_W-1:0]   act_words,
  output logic [VW-1:0]     result
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic sel;
    logic act;
    assign sel = elem64 ? mask[w / 2] : mask[w];
    assign act = (AW_W'(w) < act_words);
    assign result[w*32 +: 32] = !act     ? 32'd0 :
                                sel      ? loaded[w*32 +: 32] :
                                zero_mode ? 32'd0 : old_val[w*32 +: 32];
  end
endmodule

// File: rtl/masked_vec_load.sv
module masked_vec_load
  import mvl_pkg::*;
#(
  parameter int LANES_MAX = 4,
  parameter int ADDR_W    = 32,
  localparam int LOG_MAX  = $clog2(LANES_MAX),
  localparam int LCW      = (LOG_MAX < 1) ? 1 : $clog2(LOG_MAX + 1),
  localparam int MASK_W   = 4 * LANES_MAX,
  localparam int VW       = 128 * LANES_MAX,
  localparam int CNT_W    = $clog2(MASK_W) + 1,
  localparam int AW_W     = $clog2(4 * LANES_MAX) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_elem64,
  input  logic [LCW-1:0]    req_lanes,
  input  logic [MASK_W-1:0] req_mask,
  input  logic              req_zero,
  input  logic              req_aligned,
  input  logic              req_scalar,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [63:0]       mem_rd_data,
  input  logic              mem_rd_fault,
  input  logic [VW-1:0]     dst_old,
  output logic              reg_wr_en,
  output logic [VW-1:0]     reg_wr_data,
  output logic              done,
  output logic [1:0]        fault_code
);
  logic [ADDR_W-1:0] addr_q;
  logic              e64_q, zero_q, algn_q, scal_q;
  logic [LCW-1:0]    lanes_q;
  logic [MASK_W-1:0] mask_q;
  logic [VW-1:0]     old_q;
  logic [CNT_W-1:0]  elem_cnt;
  logic [AW_W-1:0]   act_words;
  logic              misaligned;
  logic              idle;
  logic              accept;
  logic [VW-1:0]     loaded;

  assign req_ready = idle;
  assign accept    = req_valid && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      e64_q   <= 1'b0;
      zero_q  <= 1'b0;
      algn_q  <= 1'b0;
      scal_q  <= 1'b0;
      lanes_q <= '0;
      mask_q  <= '0;
      old_q   <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      e64_q   <= req_elem64;
      zero_q  <= req_zero;
      algn_q  <= req_aligned;
      scal_q  <= req_scalar;
      lanes_q <= req_lanes;
      mask_q  <= req_mask;
      old_q   <= dst_old;
    end
  end

  mvl_shape #(.LANES_MAX(LANES_MAX), .ADDR_W(ADDR_W)) u_shape (
    .addr       (addr_q),
    .elem64     (e64_q),
    .lanes_code (lanes_q),
    .scalar     (scal_q),
    .aligned    (algn_q),
    .elem_cnt   (elem_cnt),
    .act_words  (act_words),
    .misaligned (misaligned)
  );

  mvl_seq #(.LANES_MAX(LANES_MAX), .ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept),
    .misaligned   (misaligned),
    .elem_cnt     (elem_cnt),
    .mask         (mask_q),
    .elem64       (e64_q),
    .base_addr    (addr_q),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_data  (mem_rd_data),
    .mem_rd_fault (mem_rd_fault),
    .loaded       (loaded),
    .idle         (idle),
    .wr_en        (reg_wr_en),
    .done         (done),
    .fault_code   (fault_code)
  );

  mvl_merge #(.LANES_MAX(LANES_MAX)) u_merge (
    .loaded    (loaded),
    .old_val   (old_q),
    .mask      (mask_q),
    .elem64    (e64_q),
    .zero_mode (zero_q),
    .act_words (act_words),
    .result    (reg_wr_data)
  );

  p_fault_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_code != FC_NONE) |-> !$past(reg_wr_en));

  p_align_no_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_code == FC_ALIGN) |-> !$past(mem_rd_valid));

  p_busy_blocks_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || reg_wr_en || done) |-> !req_ready);
endmodule

// File: tb/tb_masked_vec_load.sv
module tb_masked_vec_load;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic         req_elem64 = 1'b0;
  logic [1:0]   req_lanes = '0;
  logic [15:0]  req_mask = '0;
  logic         req_zero = 1'b0;
  logic         req_aligned = 1'b0;
  logic         req_scalar = 1'b0;
  logic         mem_rd_valid;
  logic         mem_rd_ready = 1'b1;
  logic [31:0]  mem_rd_addr;
  logic [63:0]  mem_rd_data;
  logic         mem_rd_fault;
  logic [511:0] dst_old = '0;
  logic         reg_wr_en;
  logic [511:0] reg_wr_data;
  logic         done;
  logic [1:0]   fault_code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // memory model state
  bit          stall_en = 0;
  int          stall_ph = 0;
  bit          fault_en = 0;
  logic [31:0] fault_addr = '0;
  logic [31:0] op_base = '0;
  bit          op_e64 = 0;
  logic [15:0] op_mask = '0;
  int          op_cnt = 0;
  int          hs_count = 0;
  int          bad_acc = 0;
  int          bp_viol = 0;
  bit          prev_wait = 0;
  logic [31:0] prev_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  masked_vec_load dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_elem64(req_elem64), .req_lanes(req_lanes), .req_mask(req_mask),
    .req_zero(req_zero), .req_aligned(req_aligned), .req_scalar(req_scalar),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_rd_fault(mem_rd_fault), .dst_old(dst_old),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .done(done), .fault_code(fault_code)
  );

  function automatic logic [31:0] mem_lo(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [31:0] mem_hi(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h0F0F_F0F0;
  endfunction

  assign mem_rd_data  = {mem_hi(mem_rd_addr), mem_lo(mem_rd_addr)};
  assign mem_rd_fault = fault_en && (mem_rd_addr == fault_addr);

  // Ready is chosen first, then the handshake for the coming edge is logged.
  always @(negedge clk) begin
    int off;
    int ix;
    stall_ph = stall_ph + 1;
    mem_rd_ready = !stall_en || (stall_ph % 3 != 0);
    if (prev_wait && (!mem_rd_valid || mem_rd_addr != prev_addr)) bp_viol++;
    if (mem_rd_valid && mem_rd_ready) begin
      hs_count++;
      off = int'(mem_rd_addr - op_base);
      ix  = op_e64 ? off / 8 : off / 4;
      if ((off % (op_e64 ? 8 : 4)) != 0 || ix >= op_cnt || !op_mask[ix]) bad_acc++;
    end
    prev_wait = mem_rd_valid && !mem_rd_ready;
    prev_addr = mem_rd_addr;
  end

  task automatic chk(input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [511:0] mk_old(input logic [31:0] seed);
    logic [511:0] v;
    for (int w = 0; w < 16; w++) v[w*32 +: 32] = seed ^ (32'(w) * 32'h0101_0101);
    return v;
  endfunction

  task automatic run_op(input string tag, input logic [31:0] base, input bit e64,
                        input logic [1:0] lc, input logic [15:0] msk, input bit zm,
                        input bit al, input bit sc, input logic [511:0] old,
                        input bit fen, input logic [31:0] faddr, input bit stall);
    int lanes, cnt, aw, exp_hs, exp_fc, wr_k, done_k, got_wr;
    logic [511:0] exp_v, wr_d;
    logic [1:0] fc;
    bit selw;
    int e;
    logic [31:0] ea;
    lanes = 1 << ((lc > 2) ? 2 : int'(lc));
    cnt   = sc ? 1 : (e64 ? 2 * lanes : 4 * lanes);
    aw    = sc ? (e64 ? 2 : 1) : 4 * lanes;
    exp_hs = 0;
    exp_fc = 0;
    if (al && !sc && ((base & 32'(16 * lanes - 1)) != 0)) exp_fc = 1;
    else begin
      for (int k = 0; k < cnt; k++) begin
        if (msk[k]) begin
          exp_hs++;
          if (fen && (base + 32'(k * (e64 ? 8 : 4)) == faddr)) begin
            exp_fc = 2;
            break;
          end
        end
      end
    end
    for (int w = 0; w < 16; w++) begin
      e    = e64 ? w / 2 : w;
      selw = (e < cnt) && msk[e];
      ea   = base + 32'(e * (e64 ? 8 : 4));
      if (w >= aw)    exp_v[w*32 +: 32] = 32'd0;
      else if (selw)  exp_v[w*32 +: 32] = (e64 && (w % 2 == 1)) ? mem_hi(ea) : mem_lo(ea);
      else if (zm)    exp_v[w*32 +: 32] = 32'd0;
      else            exp_v[w*32 +: 32] = old[w*32 +: 32];
    end

    @(negedge clk);
    op_base = base; op_e64 = e64; op_mask = sc ? {15'd0, msk[0]} : msk; op_cnt = cnt;
    hs_count = 0; bad_acc = 0; bp_viol = 0;
    stall_en = stall; fault_en = fen; fault_addr = faddr;
    req_addr = base; req_elem64 = e64; req_lanes = lc; req_mask = msk;
    req_zero = zm; req_aligned = al; req_scalar = sc; dst_old = old;
    req_valid = 1'b1;
    chk("R9", "req_ready when idle", 512'(req_ready), 512'(1));
    @(negedge clk);
    req_valid = 1'b0;
    dst_old = ~old;
    got_wr = 0; wr_k = -1; done_k = -1; wr_d = '0; fc = '0;
    for (int k = 0; k < 400; k++) begin
      if (reg_wr_en) begin got_wr++; wr_d = reg_wr_data; wr_k = k; end
      if (done) begin done_k = k; fc = fault_code; break; end
      @(negedge clk);
    end
    chk("R6 R7", "fault code", 512'(fc), 512'(exp_fc));
    chk("R6 R7", "done seen", 512'(done_k >= 0), 512'(1));
    chk("R2", "memory beats", 512'(hs_count), 512'(exp_hs));
    chk("R1", "unselected or stray access", 512'(bad_acc), 512'(0));
    chk("R9", "stall hold violations", 512'(bp_viol), 512'(0));
    if (exp_fc == 0) begin
      chk("R10", "write count", 512'(got_wr), 512'(1));
      chk("R10", "done one cycle after write", 512'(done_k - wr_k), 512'(1));
      chk(tag, "write data", wr_d, exp_v);
    end else begin
      chk("R7", "no write on fault", 512'(got_wr), 512'(0));
    end
    @(negedge clk);
    chk("R10", "done single pulse", 512'(done), 512'(0));
    fault_en = 0; stall_en = 0;
  endtask

  task automatic t_reset();
    chk("R11", "req_ready", 512'(req_ready), 512'(1));
    chk("R11", "mem_rd_valid", 512'(mem_rd_valid), 512'(0));
    chk("R11", "reg_wr_en", 512'(reg_wr_en), 512'(0));
    chk("R11", "done", 512'(done), 512'(0));
  endtask

  task automatic t_zero_mode();
    run_op("R3", 32'h0000_1000, 0, 2'd2, 16'hA5C3, 1, 1, 0, mk_old(32'hDEAD_0000), 0, 0, 1);
    run_op("R3", 32'h0000_1800, 1, 2'd3, 16'h00B6, 1, 0, 0, mk_old(32'h1111_2222), 0, 0, 0);
  endtask

  task automatic t_merge_mode();
    run_op("R4", 32'h0000_2008, 1, 2'd1, 16'hFF09, 0, 0, 0, mk_old(32'hCAFE_0000), 0, 0, 1);
    run_op("R4", 32'h0000_2100, 0, 2'd2, 16'h3C0F, 0, 1, 0, mk_old(32'hBEEF_1234), 0, 0, 0);
  endtask

  task automatic t_short_length();
    run_op("R5", 32'h0000_3004, 0, 2'd0, 16'hFFF6, 0, 0, 0, {16{32'hFFFF_FFFF}}, 0, 0, 1);
    run_op("R5", 32'h0000_3020, 1, 2'd1, 16'h0005, 1, 1, 0, {16{32'hFFFF_FFFF}}, 0, 0, 0);
  endtask

  task automatic t_empty_mask();
    run_op("R2", 32'h0000_3400, 0, 2'd2, 16'h0000, 0, 0, 0, mk_old(32'h7777_0000), 0, 0, 0);
  endtask

  task automatic t_alignment();
    run_op("R6", 32'h0000_1020, 0, 2'd2, 16'hFFFF, 1, 1, 0, mk_old(32'h0), 0, 0, 0);
    run_op("R6", 32'h0000_1020, 0, 2'd1, 16'h00FF, 1, 1, 0, mk_old(32'h0), 0, 0, 0);
    run_op("R6", 32'h0000_1004, 1, 2'd2, 16'h00FF, 0, 0, 0, mk_old(32'h4), 0, 0, 1);
  endtask

  task automatic t_mem_fault();
    run_op("R7", 32'h0000_4000, 0, 2'd2, 16'h00FF, 1, 0, 0, mk_old(32'h9), 1, 32'h0000_4008, 1);
    run_op("R7", 32'h0000_4000, 0, 2'd2, 16'h00FB, 0, 0, 0, mk_old(32'h9), 1, 32'h0000_4008, 0);
    run_op("R7", 32'h0000_4800, 1, 2'd2, 16'h0081, 0, 0, 0, mk_old(32'h3), 1, 32'h0000_4838, 0);
  endtask

  task automatic t_scalar();
    run_op("R8", 32'h0000_5008, 1, 2'd2, 16'hFFFF, 0, 1, 1, mk_old(32'hABCD_0000), 0, 0, 1);
    run_op("R8", 32'h0000_5003, 0, 2'd0, 16'hFFFE, 0, 1, 1, mk_old(32'h1357_0000), 0, 0, 0);
    run_op("R8", 32'h0000_5010, 1, 2'd1, 16'h0002, 1, 0, 1, mk_old(32'h2468_0000), 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_mode();
    t_merge_mode();
    t_short_length();
    t_empty_mask();
    t_alignment();
    t_mem_fault();
    t_scalar();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule